// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a vector of level-sensitive peripheral interrupt lines and produces one interrupt request per CPU. The lines are grouped into 32-bit words. Every CPU owns a private bank of registers. The bank holds one read/write enable word for each group of 32 sources, followed by one read-only status word for each group. A CPU's request is raised while at least one source is both active and enabled in that CPU's bank.

Software masks or unmasks a source by rewriting the whole enable word that contains it. There are no separate set or clear registers. To steer a source to another CPU, software clears the bit in one bank and sets it in the other. Inside a bank the words run in big-endian order: the lowest address holds the highest-numbered group of sources. The register port is a plain 32-bit bus that completes every access in the cycle it is presented.

Top module: `percpu_irq_gate`

## Requirements
- R1: Each register word covers 32 sources and the number of words per CPU is the parameter WORDS. Input bit n of `irqIn` is source n, with 32*WORDS sources in total.
- R2: CPU c's bank starts at byte offset c*8*WORDS. Its enable word i sits at bank offset 4*i and its status word i at bank offset 4*(WORDS+i), for i from 0 to WORDS-1. Address bits [1:0] are ignored.
- R3: Word i of either region, enable or status, covers sources 32*(WORDS-1-i) to 32*(WORDS-1-i)+31. Bit b of that word is source 32*(WORDS-1-i)+b. With the defaults, offset 0x00 holds sources 63..32 and offset 0x04 holds sources 31..0.
- R4: A write to an enable word replaces all 32 bits at the clock edge. A read returns the last value written. Bits are never merged with the previous contents.
- R5: Reset clears every enable word of every CPU, so each `irqOut` bit is low after reset.
- R6: `irqOut[c]` is a register holding the OR over all sources of (status AND CPU c's enable). It changes at the first rising edge after an enable word changes, and at the second rising edge after a source line changes.
- R7: A status word reads the level of its sources as captured at the most recent rising edge. Writes to status offsets change no state.
- R8: Offsets at or above NUM_CPUS*8*WORDS read as zero, and writes to them change no state.
- R9: `busReady` equals `busSel` in the same cycle. Read data is valid in the cycle of the request.
- R10: Banks are independent. An enable word written for one CPU has no effect on another CPU's registers or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32*WORDS | Level interrupt sources, bit n is source n |
| busSel | input | 1 | Access request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset inside the block window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the request cycle |
| busReady | output | 1 | Access completes this cycle |
| irqOut | output | NUM_CPUS | One registered interrupt request per CPU |

## Verification
Three latencies matter here. Read data and ready are due in the same cycle as the request, so the bench samples them a short delay after driving the bus, before the next edge. A new enable word reaches `irqOut` at the edge after the write edge. A source change takes two edges: one into the status register and one into the output register. The bench changes inputs on falling edges and samples `irqOut` only on the falling edge after the edge where the value is due. The directed timing tests also sample one edge early, which confirms the output has not moved before it is due.

// File: rtl/irqgate_pkg.sv
package irqgate_pkg;
  // Width of the CPU and group indices carried in the strobe bundle.
  localparam int IDX_W = 4;
  localparam int WORD_BITS = 32;

  // Decoded register access, handed from control to datapath.
  typedef struct packed {
    logic             enWrite;   // write one enable word
    logic             enRead;    // read one enable word
    logic             stRead;    // read one status word
    logic [IDX_W-1:0] cpu;       // addressed bank
    logic [IDX_W-1:0] grp;       // source group (0 = sources 31..0)
  } regStrobe_t;
endpackage

// File: rtl/irqgate_ctrl.sv
module irqgate_ctrl
  import irqgate_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int WORDS    = 2,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam int BANK_BYTES = 8 * WORDS;

  int offs;
  int bankN;
  int wordN;
  logic inMap;
  logic isEn;

  always_comb begin
    offs  = int'(busAddr);
    bankN = offs / BANK_BYTES;
    wordN = (offs % BANK_BYTES) / 4;
    inMap = busSel && (bankN < NUM_CPUS);
    isEn  = wordN < WORDS;
    strobe = '0;
    strobe.cpu = IDX_W'(bankN);
    // Word order is reversed: lowest word holds the highest group.
    strobe.grp = isEn ? IDX_W'(WORDS - 1 - wordN) : IDX_W'(2 * WORDS - 1 - wordN);
    strobe.enWrite = inMap && isEn && busWe;
    strobe.enRead  = inMap && isEn && !busWe;
    strobe.stRead  = inMap && !isEn && !busWe;
  end

  AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enWrite, strobe.enRead, strobe.stRead})); // R2

  AST_DECODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enWrite || strobe.enRead || strobe.stRead) |->
      (32'(strobe.cpu) < NUM_CPUS && 32'(strobe.grp) < WORDS)); // R8

  AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enWrite |-> (busSel && busWe)); // R4
endmodule

// File: rtl/irqgate_dp.sv
module irqgate_dp
  import irqgate_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int WORDS    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [32*WORDS-1:0]    irqIn,
  input  logic [31:0]            wrData,
  input  regStrobe_t             strobe,
  output logic [31:0]            rdData,
  output logic [NUM_CPUS-1:0]    irqOut
);
  localparam int SRC = WORD_BITS * WORDS;

  logic [SRC-1:0]      statusQ;
  logic [31:0]         enQ      [NUM_CPUS][WORDS];
  logic [SRC-1:0]      cpuEnSrc [NUM_CPUS];
  logic [NUM_CPUS-1:0] irqQ;

  // Raw level capture of every source.
  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= irqIn;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar g = 0; g < WORDS; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (!rstN)
          enQ[c][g] <= '0;
        else if (strobe.enWrite && strobe.cpu == IDX_W'(c) && strobe.grp == IDX_W'(g))
          enQ[c][g] <= wrData;
      end
      assign cpuEnSrc[c][g*32 +: 32] = enQ[c][g];

      AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.enWrite && strobe.cpu == IDX_W'(c) && strobe.grp == IDX_W'(g))
          |=> (enQ[c][g] == $past(wrData))); // R4

      AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !(strobe.enWrite && strobe.cpu == IDX_W'(c) && strobe.grp == IDX_W'(g))
          |=> $stable(enQ[c][g])); // R8

      AST_EN_RESET: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rstN) |-> (enQ[c][g] == '0)); // R5
    end

    always_ff @(posedge clk) begin
      if (!rstN) irqQ[c] <= 1'b0;
      else       irqQ[c] <= |(statusQ & cpuEnSrc[c]);
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (cpuEnSrc[c] == '0) |=> !irqOut[c]); // R6
  end

  assign irqOut = irqQ;

  // Combinational read path.
  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int g = 0; g < WORDS; g++) begin
        if (strobe.cpu == IDX_W'(c) && strobe.grp == IDX_W'(g)) begin
          if (strobe.enRead) rdData = enQ[c][g];
          if (strobe.stRead) rdData = statusQ[g*32 +: 32];
        end
      end
    end
  end
endmodule

// File: rtl/percpu_irq_gate.sv
module percpu_irq_gate
  import irqgate_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int WORDS    = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [32*WORDS-1:0] irqIn,
  input  logic                busSel,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busReady,
  output logic [NUM_CPUS-1:0] irqOut
);
  regStrobe_t strobe;

  irqgate_ctrl #(.NUM_CPUS(NUM_CPUS), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  irqgate_dp #(.NUM_CPUS(NUM_CPUS), .WORDS(WORDS)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .irqIn (irqIn),
    .wrData(busWdata),
    .strobe(strobe),
    .rdData(busRdata),
    .irqOut(irqOut)
  );

  assign busReady = busSel;

  AST_READY_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busReady == busSel); // R9
endmodule

// File: tb/sim_percpu_irq_gate.sv
module sim_percpu_irq_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [1:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  percpu_irq_gate u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .irqOut(irqOut)
  );

  // Vectors: sources, CPU0 enables, CPU1 enables (bit n = source n), expected irqOut.
  localparam logic [63:0] V_IRQ [6] = '{64'h1, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000,
                                        64'hF0F0_F0F0_F0F0_F0F0, '1, 64'h0};
  localparam logic [63:0] V_EN0 [6] = '{64'h1, 64'h0, 64'h1, 64'h0F0F_0F0F_0F0F_0F0F, '1, '1};
  localparam logic [63:0] V_EN1 [6] = '{64'h0, 64'h8000_0000_0000_0000, 64'h0, '1, '1, '1};
  localparam logic [1:0]  V_OUT [6] = '{2'b01, 2'b10, 2'b00, 2'b10, 2'b11, 2'b00};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1;
    check("R9 ready", {63'b0, busReady}, 64'h1);
    check(req, {32'b0, busRdata}, {32'b0, exp});
    #1;
    busSel = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: reset state
    check("R5 irqOut after reset", {62'b0, irqOut}, 64'h0);
    check("R9 ready idle", {63'b0, busReady}, 64'h0);
    busRead(8'h00, 32'h0, "R5 cpu0 en word0");
    busRead(8'h04, 32'h0, "R5 cpu0 en word1");
    busRead(8'h10, 32'h0, "R5 cpu1 en word0");
    busRead(8'h14, 32'h0, "R5 cpu1 en word1");

    // R1 R3 R6 R10: table of vectors
    for (int i = 0; i < 6; i++) begin
      busWrite(8'h00, V_EN0[i][63:32]);
      busWrite(8'h04, V_EN0[i][31:0]);
      busWrite(8'h10, V_EN1[i][63:32]);
      busWrite(8'h14, V_EN1[i][31:0]);
      @(negedge clk);
      irqIn = V_IRQ[i];
      waitEdges(2);
      check($sformatf("R6 R10 vector %0d irqOut", i), {62'b0, irqOut}, {62'b0, V_OUT[i]});
      busRead(8'h08, V_IRQ[i][63:32], "R3 cpu0 status word0");
      busRead(8'h0C, V_IRQ[i][31:0],  "R3 cpu0 status word1");
      busRead(8'h18, V_IRQ[i][63:32], "R1 cpu1 status word0");
      busRead(8'h04, V_EN0[i][31:0],  "R2 cpu0 en word1 readback");
    end

    // R6: source-to-output latency is two edges
    busWrite(8'h00, 32'h0); busWrite(8'h04, 32'h1);
    busWrite(8'h10, 32'h0); busWrite(8'h14, 32'h0);
    @(negedge clk); irqIn = '0;
    waitEdges(2);
    irqIn[0] = 1'b1;
    waitEdges(1);
    check("R6 not yet after one edge", {62'b0, irqOut}, 64'h0);
    waitEdges(1);
    check("R6 asserted after two edges", {62'b0, irqOut}, 64'h1);

    // R6: enable-to-output latency is one edge; R3 source 40 lives in word0 bit 8
    @(negedge clk); irqIn = 64'h0000_0100_0000_0000;
    waitEdges(2);
    check("R6 masked source quiet", {62'b0, irqOut}, 64'h0);
    busWrite(8'h00, 32'h0000_0100);
    check("R6 not yet at write edge", {62'b0, irqOut}, 64'h0);
    waitEdges(1);
    check("R3 R6 source40 asserts", {62'b0, irqOut}, 64'h1);
    check("R10 cpu1 unaffected", {63'b0, irqOut[1]}, 64'h0);

    // R7: status write ignored
    busWrite(8'h08, 32'h0);
    busWrite(8'h0C, 32'hFFFF_FFFF);
    busRead(8'h08, 32'h0000_0100, "R7 status word0 after write");
    busRead(8'h0C, 32'h0, "R7 status word1 after write");
    check("R7 irqOut after status write", {62'b0, irqOut}, 64'h1);

    // R4: whole-word replace
    busWrite(8'h14, 32'hDEAD_BEEF);
    busRead(8'h14, 32'hDEAD_BEEF, "R4 readback");
    busWrite(8'h14, 32'h0000_0001);
    busRead(8'h14, 32'h0000_0001, "R4 replace not merge");

    // R8: unmapped offsets
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'hFC, 32'hFFFF_FFFF);
    busRead(8'h20, 32'h0, "R8 unmapped read");
    busRead(8'hFC, 32'h0, "R8 unmapped read high");
    busRead(8'h00, 32'h0000_0100, "R8 cpu0 word0 untouched");
    busRead(8'h10, 32'h0, "R8 cpu1 word0 untouched");
    check("R8 irqOut unchanged", {62'b0, irqOut}, 64'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule